// File: doc/BRIEF.md
# Modular Butterfly Element for a 256-Point Lattice Transform

This block is the arithmetic core of a forward number theoretic transform over polynomials whose coefficients live modulo 3329. On every clock cycle it can take one pair of coefficients `a` and `b` together with a twiddle index. It looks up the twiddle `z` in a constant table held inside the block and returns the Cooley–Tukey pair `a + z·b` and `a − z·b`, both fully reduced modulo 3329.

The product `z·b` is reduced with Montgomery reduction. To make that work, the table stores each twiddle already multiplied by 2^16 mod 3329, so the product comes back out in the normal domain. The sum and the difference are each reduced with a Barrett step that uses floor(2^26/3329) and one conditional subtraction. The difference path adds the modulus before reduction, so no value ever goes negative.

The pipeline has a fixed depth and cannot stall. A sequencer outside the block feeds it pairs and twiddle indices in transform order, and collects the results a fixed number of cycles later.

Top module: `ntt_bfly_pe`

## Requirements
- R1: Whenever `out_valid` is high, both `out_sum` and `out_dif` lie in the range 0 to 3328.
- R2: For an accepted input with twiddle value z, `out_sum` equals (in_a + z·in_b) mod 3329.
- R3: For an accepted input with twiddle value z, `out_dif` equals (in_a − z·in_b) mod 3329, taken as a non-negative residue.
- R4: The twiddle value for index k (0 to 127, `in_idx` read as an unsigned 7-bit number) is 17^rev(k) mod 3329. Here rev(k) reverses the order of the 7 bits of k.
- R5: An input sampled with `in_valid` high on a rising edge produces its result on the outputs after the fourth rising edge counted from that one. `out_valid` is high in exactly that cycle.
- R6: A new input can be accepted on every cycle with no gap. Back-to-back inputs produce back-to-back results in the same order.
- R7: While `rst_n` is low, `out_valid` is low, and it goes low immediately when reset is asserted. After reset, `out_valid` stays low until the first accepted input reaches the output.
- R8: The corner operands 0 and 3328 for `in_a` and `in_b`, with any twiddle index, give correctly reduced results.
- R9: A cycle with `in_valid` low produces no result: four edges later `out_valid` is low, whatever `in_a`, `in_b` and `in_idx` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| in_valid | input | 1 | Marks the current operands as a butterfly to compute |
| in_a | input | 12 | Upper coefficient, below 3329 |
| in_b | input | 12 | Lower coefficient, multiplied by the twiddle, below 3329 |
| in_idx | input | 7 | Twiddle table index |
| out_valid | output | 1 | Result qualifier, four edges after the input |
| out_sum | output | 12 | (a + z·b) mod 3329 |
| out_dif | output | 12 | (a − z·b) mod 3329 |

## Verification
The range and pair-sum assertions assume that both operands are below 3329 whenever `in_valid` is high. Operands of 3329 or more would overflow the single conditional correction after the Barrett step. They also assume that reset is released away from a rising edge. The stimulus therefore draws every valid operand modulo 3329 or from the corner set {0, 3328}. It puts wide, out-of-range values on `in_a` and `in_b` only during cycles with `in_valid` low, and it changes `rst_n` only on falling clock edges.

// File: rtl/ntt_pe_pkg.sv
package ntt_pe_pkg;

  localparam int unsigned COEF_MOD      = 3329;
  localparam int unsigned POLY_LEN      = 256;
  localparam int unsigned ROOT_OF_UNITY = 17;
  localparam int unsigned MONT_SHIFT    = 16;
  localparam int unsigned MONT_NEG_QINV = 3327;
  localparam int unsigned BAR_SHIFT     = 26;
  localparam int unsigned PIPE_LAT      = 4;

  // reverse the low 'bits' bits of v
  function automatic int unsigned bit_rev(int unsigned v, int unsigned bits);
    int unsigned r;
    r = 0;
    for (int unsigned j = 0; j < bits; j++) begin
      r = r | (((v >> j) & 1) << (bits - 1 - j));
    end
    return r;
  endfunction

endpackage

// File: rtl/ntt_twiddle_rom.sv
module ntt_twiddle_rom #(
  parameter int unsigned N_POINTS = ntt_pe_pkg::POLY_LEN,
  parameter int unsigned MOD      = ntt_pe_pkg::COEF_MOD,
  parameter int unsigned ROOT     = ntt_pe_pkg::ROOT_OF_UNITY,
  parameter int unsigned RW       = ntt_pe_pkg::MONT_SHIFT,
  localparam int unsigned IDX_W   = $clog2(N_POINTS) - 1,
  localparam int unsigned DEPTH   = N_POINTS / 2,
  localparam int unsigned CW      = $clog2(MOD)
) (
  input  logic             clk,
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [CW-1:0]    tw_q
);

  // twiddle in Montgomery form: ROOT^rev(k) * 2^RW mod MOD
  function automatic int unsigned tw_entry(int unsigned k);
    int unsigned e;
    int unsigned acc;
    e   = ntt_pe_pkg::bit_rev(k, IDX_W);
    acc = 1;
    for (int unsigned s = 0; s < e; s++) begin
      acc = (acc * ROOT) % MOD;
    end
    return (acc * (32'd1 << RW)) % MOD;
  endfunction

  logic [CW-1:0] table_w [DEPTH];
  logic [CW-1:0] tw_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign table_w[g] = CW'(tw_entry(g));
  end

  always_comb begin
    tw_d = en ? table_w[idx] : tw_q;
  end

  always_ff @(posedge clk) begin
    tw_q <= tw_d;
  end

endmodule

// File: rtl/ntt_mont_mul.sv
module ntt_mont_mul #(
  parameter int unsigned MOD  = ntt_pe_pkg::COEF_MOD,
  parameter int unsigned RW   = ntt_pe_pkg::MONT_SHIFT,
  parameter int unsigned QNEG = ntt_pe_pkg::MONT_NEG_QINV,
  localparam int unsigned CW  = $clog2(MOD),
  localparam int unsigned PW  = 2 * CW,
  localparam int unsigned SW  = RW + CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_mul,
  input  logic          en_red,
  input  logic [CW-1:0] op_b,
  input  logic [CW-1:0] op_w,
  output logic [CW-1:0] res_q
);

  localparam logic [RW-1:0] QNEG_C = RW'(QNEG);
  localparam logic [CW:0]   MOD_X  = (CW+1)'(MOD);
  localparam logic [CW-1:0] MOD_C  = CW'(MOD);

  logic [PW-1:0] prod_q, prod_d;
  logic [RW-1:0] m_lo;
  logic [SW-1:0] mont_sum;
  logic [CW:0]   t_red;
  logic [CW-1:0] res_d;

  // stage A: raw product
  always_comb begin
    prod_d = en_mul ? (PW'(op_b) * PW'(op_w)) : prod_q;
  end

  // stage B: (p + m*q) / 2^RW, then one correction
  always_comb begin
    m_lo     = prod_q[RW-1:0] * QNEG_C;
    mont_sum = SW'(prod_q) + SW'(m_lo) * SW'(MOD);
    t_red    = mont_sum[SW-1:RW];
    if (!en_red) begin
      res_d = res_q;
    end else if (t_red >= MOD_X) begin
      res_d = CW'(t_red - MOD_X);
    end else begin
      res_d = CW'(t_red);
    end
  end

  always_ff @(posedge clk) begin
    prod_q <= prod_d;
    res_q  <= res_d;
  end

  // low half must cancel exactly, else the constant is wrong (feeds R2)
  assert_mont_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_red |-> (mont_sum[RW-1:0] == '0));

  assert_mont_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en_red |=> (res_q < MOD_C));

endmodule

// File: rtl/ntt_barrett_red.sv
module ntt_barrett_red #(
  parameter int unsigned MOD   = ntt_pe_pkg::COEF_MOD,
  parameter int unsigned SHIFT = ntt_pe_pkg::BAR_SHIFT,
  localparam int unsigned CW   = $clog2(MOD),
  localparam int unsigned XW   = CW + 1,
  localparam int unsigned MUL  = (32'd1 << SHIFT) / MOD,
  localparam int unsigned MW   = $clog2(MUL + 1),
  localparam int unsigned PW   = XW + MW,
  localparam int unsigned QW   = PW - SHIFT
) (
  input  logic [XW-1:0] x,
  output logic [CW-1:0] r
);

  localparam logic [XW-1:0] MOD_X = XW'(MOD);

  logic [PW-1:0] prod;
  logic [QW-1:0] quot;
  logic [XW-1:0] qm;
  logic [XW-1:0] rem;

  always_comb begin
    prod = PW'(x) * PW'(MUL);
    quot = QW'(prod >> SHIFT);
    qm   = XW'(quot) * MOD_X;
    rem  = x - qm;
    r    = (rem >= MOD_X) ? CW'(rem - MOD_X) : CW'(rem);
  end

endmodule

// File: rtl/ntt_bfly_pe.sv
module ntt_bfly_pe #(
  parameter int unsigned N_POINTS = ntt_pe_pkg::POLY_LEN,
  parameter int unsigned MOD      = ntt_pe_pkg::COEF_MOD,
  localparam int unsigned CW      = $clog2(MOD),
  localparam int unsigned XW      = CW + 1,
  localparam int unsigned IDX_W   = $clog2(N_POINTS) - 1,
  localparam int unsigned LAT     = ntt_pe_pkg::PIPE_LAT,
  localparam int unsigned NLANE   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CW-1:0]    in_a,
  input  logic [CW-1:0]    in_b,
  input  logic [IDX_W-1:0] in_idx,
  output logic             out_valid,
  output logic [CW-1:0]    out_sum,
  output logic [CW-1:0]    out_dif
);

  localparam logic [XW-1:0] MOD_X = XW'(MOD);
  localparam logic [CW-1:0] MOD_C = CW'(MOD);

  logic [LAT-1:0] vld_q, vld_d;
  logic [CW-1:0]  a_q [LAT-1];
  logic [CW-1:0]  a_d [LAT-1];
  logic [CW-1:0]  b_q, b_d;
  logic [CW-1:0]  tw_q;
  logic [CW-1:0]  wb;
  logic [XW-1:0]  lane_x [NLANE];
  logic [CW-1:0]  lane_r [NLANE];
  logic [CW-1:0]  res_q  [NLANE];
  logic [CW-1:0]  res_d  [NLANE];

  // valid shift chain: the only reset state on the datapath side
  always_comb begin
    vld_d = {vld_q[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // operand a rides alongside the multiplier stages
  always_comb begin
    a_d[0] = in_valid ? in_a : a_q[0];
    for (int k = 1; k < LAT - 1; k++) begin
      a_d[k] = vld_q[k-1] ? a_q[k-1] : a_q[k];
    end
    b_d = in_valid ? in_b : b_q;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LAT - 1; k++) begin
      a_q[k] <= a_d[k];
    end
    b_q <= b_d;
  end

  ntt_twiddle_rom #(
    .N_POINTS(N_POINTS),
    .MOD     (MOD)
  ) u_rom (
    .clk (clk),
    .en  (in_valid),
    .idx (in_idx),
    .tw_q(tw_q)
  );

  ntt_mont_mul #(
    .MOD(MOD)
  ) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .en_mul(vld_q[0]),
    .en_red(vld_q[1]),
    .op_b  (b_q),
    .op_w  (tw_q),
    .res_q (wb)
  );

  // lane 0: a + wb ; lane 1: a + q - wb (kept non-negative)
  always_comb begin
    lane_x[0] = XW'(a_q[LAT-2]) + XW'(wb);
    lane_x[1] = XW'(a_q[LAT-2]) + MOD_X - XW'(wb);
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    ntt_barrett_red #(
      .MOD(MOD)
    ) u_red (
      .x(lane_x[l]),
      .r(lane_r[l])
    );

    always_comb begin
      res_d[l] = vld_q[LAT-2] ? lane_r[l] : res_q[l];
    end

    always_ff @(posedge clk) begin
      res_q[l] <= res_d[l];
    end
  end

  assign out_valid = vld_q[LAT-1];
  assign out_sum   = res_q[0];
  assign out_dif   = res_q[1];

  // cycles since reset, saturating, so $past never reaches before reset
  logic [2:0] rst_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rst_age <= '0;
    else if (rst_age != 3'd4) rst_age <= rst_age + 3'd1;
  end

  assert_out_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_sum < MOD_C) && (out_dif < MOD_C)));

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_age == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // sum + difference must equal 2a mod q for the operand seen 4 edges ago
  assert_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rst_age == 3'd4) && out_valid) |->
      (((XW'(out_sum) + XW'(out_dif)) % MOD_X) ==
       ((XW'($past(in_a, 4)) << 1) % MOD_X)));

endmodule

// File: tb/ntt_bfly_pe_bench.sv
module ntt_bfly_pe_bench;

  localparam int unsigned QM   = 3329;
  localparam int          CLKP = 8;
  localparam int          NV   = 12;

  localparam int unsigned VEC_A [NV] = '{5, 0, 3328, 1, 1664, 2000, 3328, 17, 1234, 3000, 0, 777};
  localparam int unsigned VEC_B [NV] = '{7, 0, 3328, 1, 1665, 3328, 0, 1, 2345, 3100, 3328, 888};
  localparam int unsigned VEC_I [NV] = '{0, 1, 127, 64, 2, 33, 100, 1, 85, 126, 5, 42};

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [11:0] in_a;
  logic [11:0] in_b;
  logic [6:0]  in_idx;
  logic        out_valid;
  logic [11:0] out_sum;
  logic [11:0] out_dif;

  int          n_run;
  int          n_fail;
  int          cyc;
  bit          mon_en;
  int unsigned ex_sum [2048];
  int unsigned ex_dif [2048];
  int          ex_due [2048];
  string       ex_tag [2048];
  int          wr_p;
  int          rd_p;

  ntt_bfly_pe u_ntt_bfly_pe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_a     (in_a),
    .in_b     (in_b),
    .in_idx   (in_idx),
    .out_valid(out_valid),
    .out_sum  (out_sum),
    .out_dif  (out_dif)
  );

  initial clk = 1'b0;
  always #(CLKP/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // R4 model: 17^rev7(k) mod q
  function automatic int unsigned zeta(int unsigned k);
    int unsigned br;
    int unsigned z;
    br = 0;
    for (int j = 0; j < 7; j++) br = br | (((k >> j) & 1) << (6 - j));
    z = 1;
    for (int unsigned e = 0; e < br; e++) z = (z * 17) % QM;
    return z;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic drive(input int unsigned a, input int unsigned b, input int unsigned k,
                       input string tag);
    int unsigned zb;
    @(negedge clk);
    in_valid = 1'b1;
    in_a     = 12'(a);
    in_b     = 12'(b);
    in_idx   = 7'(k);
    zb       = (zeta(k) * b) % QM;
    ex_sum[wr_p] = (a + zb) % QM;
    ex_dif[wr_p] = (a + QM - zb) % QM;
    ex_due[wr_p] = cyc + 4;
    ex_tag[wr_p] = tag;
    wr_p++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_a     = 12'hFFF;
      in_b     = 12'(4000 + i);
      in_idx   = 7'(i);
    end
  endtask

  // monitor: sample 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (mon_en && rst_n) begin
      if (rd_p < wr_p && ex_due[rd_p] == cyc) begin
        check(out_valid == 1'b1, "R5 out_valid at due cycle", int'(out_valid), 1);
        check(out_sum == 12'(ex_sum[rd_p]), {ex_tag[rd_p], " R2 out_sum"},
              int'(out_sum), int'(ex_sum[rd_p]));
        check(out_dif == 12'(ex_dif[rd_p]), {ex_tag[rd_p], " R3 out_dif"},
              int'(out_dif), int'(ex_dif[rd_p]));
        check((out_sum < 12'd3329) && (out_dif < 12'd3329), "R1 range",
              int'(out_sum), int'(out_dif));
        rd_p++;
      end else begin
        check(out_valid == 1'b0, "R9 no result without input", int'(out_valid), 0);
      end
    end
  end

  initial begin
    #(CLKP * 200000);
    n_fail++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run    = 0;
    n_fail   = 0;
    wr_p     = 0;
    rd_p     = 0;
    mon_en   = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b1;
    in_a     = 12'd5;
    in_b     = 12'd5;
    in_idx   = 7'd0;

    // R7: reset state, even with in_valid high
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7 out_valid in reset", int'(out_valid), 0);
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst_n  = 1'b1;
    mon_en = 1'b1;
    idle(6);

    // table walk, back to back (R2 R3 R4 R6)
    for (int i = 0; i < NV; i++) drive(VEC_A[i], VEC_B[i], VEC_I[i], "R6 table");
    idle(6);

    // corner operands over several indices (R8)
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 4; c++) begin
        drive((c & 1) ? 3328 : 0, (c & 2) ? 3328 : 0,
              (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 64 : 127, "R8 corner");
      end
    end
    idle(6);

    // every twiddle: a=0, b=1 gives z on out_sum (R4)
    for (int k = 0; k < 128; k++) drive(0, 1, k, "R4 twiddle");
    idle(6);

    // random operands with random gaps (R9 R2 R3)
    for (int i = 0; i < 300; i++) begin
      drive($urandom % QM, $urandom % QM, $urandom % 128, "R9 random");
      if (($urandom % 3) == 0) idle(1 + ($urandom % 3));
    end
    idle(8);
    check(rd_p == wr_p, "R6 all results returned", rd_p, wr_p);

    // R7: reset while the pipeline is full
    drive(10, 20, 3, "R7 flush");
    drive(11, 21, 4, "R7 flush");
    drive(12, 22, 5, "R7 flush");
    @(negedge clk);
    mon_en = 1'b0;
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0, "R7 out_valid drops on reset", int'(out_valid), 0);
    rd_p = wr_p;
    @(negedge clk);
    rst_n  = 1'b1;
    mon_en = 1'b1;
    idle(8);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule